// File: doc/BRIEF.md
# Block Address Translation Stage

This block turns a 32-bit effective address into a real address for large, contiguous regions of memory, ahead of any finer-grained translation. It holds a small set of block entries for one address space. One instance serves instruction fetches and a second instance serves data accesses. Each entry describes a region by four values: a compare mask, an effective page index that the masked address must equal, a length mask that chooses which address bits pass through unchanged, and a real page number that supplies the remaining bits. A two-bit protection code and two validity flags complete the entry. One flag enables the entry in supervisor state and the other enables it in problem state.

Software-facing logic loads the entries one field per cycle through a write port. The current privilege mode is registered, and only entries enabled for that mode and allowed for the access kind take part in a lookup. A lookup request is answered one cycle later. The answer is either a hit, which carries the real address, the protection code and the entry number, or a miss. On a miss the effective address is passed through unchanged so that a later segment and page stage can take over.

Top module: `blk_xlate`

## Requirements
- R1: After reset every entry has both validity flags clear and protection code 0, `rsp_valid` is 0, and every lookup misses until entries are loaded.
- R2: Entry i matches when it is eligible and `(req_ea & compare_mask_i) == page_index_i`.
- R3: On a hit, `rsp_ra = real_page_i | (ea & length_mask_i)`, `rsp_prot` is that entry's protection code, and `rsp_idx` is i.
- R4: When several eligible entries match, the lowest-numbered entry wins.
- R5: Control field bit 3 enables an entry in supervisor state (`problem_mode`=0), and bit 2 enables it in problem state (`problem_mode`=1). Bits 1:0 of the control field hold the protection code.
- R6: `problem_mode` is registered. A lookup presented at clock edge t uses the mode that was sampled at edge t-1, so a change of mode affects lookups only from the following cycle.
- R7: An entry whose protection code is 00 is never eligible. For a write access (`req_write`=1), only code 10 is eligible. Codes 01 and 11 are read-only.
- R8: On a miss, `rsp_hit`=0, `rsp_ra` equals the effective address, `rsp_prot`=0 and `rsp_idx`=0.
- R9: `rsp_valid` equals `req_valid` delayed by one cycle. When `req_valid` is 0, the other response outputs keep their previous values.
- R10: A write through the port has field codes 0 = page index, 1 = compare mask, 2 = length mask, 3 = real page, 4 = control (bits 3:0). The write affects lookups from the next edge onward. Field codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| problem_mode | input | 1 | Current privilege mode: 1 = problem, 0 = supervisor |
| wr_en | input | 1 | Entry field write strobe |
| wr_idx | input | 2 | Entry number to write |
| wr_field | input | 3 | Field code to write |
| wr_data | input | 32 | Field value |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Block translation hit |
| rsp_ra | output | 32 | Real address, or the effective address on a miss |
| rsp_prot | output | 2 | Protection code of the winning entry |
| rsp_idx | output | 2 | Number of the winning entry |

## Verification
The assertions assume that `req_ea` and `req_write` are known whenever `req_valid` is high, because the miss pass-through and write-protection properties compare the answer with those values one cycle later. The stimulus drives every input at the falling edge and keeps each one defined throughout the run, including the address while no request is active. The bench also checks two overlap cases directly. A field write that lands in the same cycle as a lookup must not affect that lookup. A mode flip presented together with a request must apply only to the next request.

// File: rtl/blk_xlate.sv
module blk_xlate #(
  parameter int AW   = 32,
  parameter int NENT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  problem_mode,
  input  logic                  wr_en,
  input  logic [((NENT>1)?$clog2(NENT):1)-1:0] wr_idx,
  input  logic [2:0]            wr_field,
  input  logic [AW-1:0]         wr_data,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_ea,
  input  logic                  req_write,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [AW-1:0]         rsp_ra,
  output logic [1:0]            rsp_prot,
  output logic [((NENT>1)?$clog2(NENT):1)-1:0] rsp_idx
);
  localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [2:0] F_IDX  = 3'd0;
  localparam logic [2:0] F_CMP  = 3'd1;
  localparam logic [2:0] F_LEN  = 3'd2;
  localparam logic [2:0] F_RPN  = 3'd3;
  localparam logic [2:0] F_CTRL = 3'd4;
  localparam logic [1:0] PP_NONE = 2'b00;
  localparam logic [1:0] PP_RW   = 2'b10;

  logic [AW-1:0] pidx_q [NENT];
  logic [AW-1:0] cmp_q  [NENT];
  logic [AW-1:0] len_q  [NENT];
  logic [AW-1:0] rpn_q  [NENT];
  logic [1:0]    pp_q   [NENT];
  logic [NENT-1:0] sv_q, pv_q, elig, match;
  logic          mode_q;
  logic          any_hit;
  logic [IW-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= problem_mode;
  end

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    wire sel = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pidx_q[i] <= '0;
        cmp_q[i]  <= '0;
        len_q[i]  <= '0;
        rpn_q[i]  <= '0;
        pp_q[i]   <= PP_NONE;
        sv_q[i]   <= 1'b0;
        pv_q[i]   <= 1'b0;
      end else if (sel) begin
        case (wr_field)
          F_IDX:  pidx_q[i] <= wr_data;
          F_CMP:  cmp_q[i]  <= wr_data;
          F_LEN:  len_q[i]  <= wr_data;
          F_RPN:  rpn_q[i]  <= wr_data;
          F_CTRL: begin
            sv_q[i] <= wr_data[3];
            pv_q[i] <= wr_data[2];
            pp_q[i] <= wr_data[1:0];
          end
          default: ;
        endcase
      end
    end

    assign elig[i]  = (mode_q ? pv_q[i] : sv_q[i])
                      && (pp_q[i] != PP_NONE)
                      && (!req_write || pp_q[i] == PP_RW);
    assign match[i] = elig[i] && ((req_ea & cmp_q[i]) == pidx_q[i]);
  end

  assign any_hit = |match;

  always_comb begin
    win = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (match[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ra    <= '0;
      rsp_prot  <= '0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= any_hit;
        rsp_ra   <= any_hit ? (rpn_q[win] | (req_ea & len_q[win])) : req_ea;
        rsp_prot <= any_hit ? pp_q[win] : 2'b00;
        rsp_idx  <= any_hit ? win : '0;
      end
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_ra) && $stable(rsp_hit) && $stable(rsp_prot));

  // R8
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ra == $past(req_ea) && rsp_prot == 2'b00));

  // R7
  hit_prot_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_prot != PP_NONE);

  // R7
  write_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && $past(req_write)) |-> rsp_prot == PP_RW);
endmodule

// File: tb/sim_blk_xlate.sv
module sim_blk_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        problem_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [2:0]  wr_field = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_ra;
  logic [1:0]  rsp_prot, rsp_idx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit [31:0] m_pidx [4], m_cmp [4], m_len [4], m_rpn [4];
  bit [1:0]  m_pp [4];
  bit        m_sv [4], m_pv [4];
  bit        m_mode = 0;
  bit        e_valid = 0, e_hit = 0;
  bit [31:0] e_ra = 0;
  bit [1:0]  e_prot = 0, e_idx = 0;

  always #2 clk = ~clk;

  blk_xlate u0 (
    .clk(clk), .rst_n(rst_n), .problem_mode(problem_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_field(wr_field), .wr_data(wr_data),
    .req_valid(req_valid), .req_ea(req_ea), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ra(rsp_ra),
    .rsp_prot(rsp_prot), .rsp_idx(rsp_idx)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input bit [31:0] ea, input bit rw,
                      input bit we, input int widx, input int wf, input bit [31:0] wd,
                      input bit pm, input string tag);
    int w;
    req_valid = rv; req_ea = ea; req_write = rw;
    wr_en = we; wr_idx = widx[1:0]; wr_field = wf[2:0]; wr_data = wd;
    problem_mode = pm;
    e_valid = rv;
    if (rv) begin
      w = -1;
      for (int i = 0; i < 4; i++) begin
        bit ok;
        ok = (m_mode ? m_pv[i] : m_sv[i]) && m_pp[i] != 2'b00 && (!rw || m_pp[i] == 2'b10);
        if (w < 0 && ok && ((ea & m_cmp[i]) == m_pidx[i])) w = i;
      end
      if (w >= 0) begin
        e_hit = 1; e_ra = m_rpn[w] | (ea & m_len[w]); e_prot = m_pp[w]; e_idx = w[1:0];
      end else begin
        e_hit = 0; e_ra = ea; e_prot = 0; e_idx = 0;
      end
    end
    if (we) begin
      case (wf)
        0: m_pidx[widx] = wd;
        1: m_cmp[widx]  = wd;
        2: m_len[widx]  = wd;
        3: m_rpn[widx]  = wd;
        4: begin m_sv[widx] = wd[3]; m_pv[widx] = wd[2]; m_pp[widx] = wd[1:0]; end
        default: ;
      endcase
    end
    m_mode = pm;
    @(negedge clk);
    check(tag, "rsp_valid", rsp_valid, e_valid);
    check(tag, "rsp_hit", rsp_hit, e_hit);
    check(tag, "rsp_ra", rsp_ra, e_ra);
    check(tag, "rsp_prot", rsp_prot, e_prot);
    check(tag, "rsp_idx", rsp_idx, e_idx);
  endtask

  task automatic wr(input int idx, input int f, input bit [31:0] d, input string tag);
    step(0, 32'h0, 0, 1, idx, f, d, m_mode, tag);
  endtask

  task automatic look(input bit [31:0] ea, input bit rw, input bit pm, input string tag);
    step(1, ea, rw, 0, 0, 0, 32'h0, pm, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_pidx[i] = 0; m_cmp[i] = 0; m_len[i] = 0; m_rpn[i] = 0;
      m_pp[i] = 0; m_sv[i] = 0; m_pv[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", rsp_valid, 0);
    check("R1", "rsp_hit in reset", rsp_hit, 0);
    rst_n = 1'b1;
    look(32'h0000_0000, 0, 0, "R1");
    look(32'h1234_5678, 0, 0, "R1");

    wr(0, 0, 32'h1000_0000, "R10");
    wr(0, 1, 32'hF000_0000, "R10");
    wr(0, 2, 32'h0FFF_FFFF, "R10");
    wr(0, 3, 32'h8000_0000, "R10");
    wr(0, 4, 32'h0000_000A, "R10");
    look(32'h1ABC_DEF0, 0, 0, "R2");
    look(32'h1000_0004, 1, 0, "R3");
    look(32'h2000_0000, 0, 0, "R8");
    look(32'h1000_0000, 0, 1, "R6");
    look(32'h1000_0000, 0, 1, "R5");
    look(32'h1000_0000, 0, 0, "R6");
    look(32'h1000_0000, 0, 0, "R5");

    wr(1, 0, 32'h1100_0000, "R10");
    wr(1, 1, 32'hFF00_0000, "R10");
    wr(1, 2, 32'h00FF_FFFF, "R10");
    wr(1, 3, 32'h4400_0000, "R10");
    wr(1, 4, 32'h0000_0005, "R10");
    look(32'h1122_3344, 0, 0, "R4");
    look(32'h1122_3344, 0, 1, "R5");
    look(32'h1122_3344, 0, 1, "R5");
    look(32'h1122_3344, 1, 1, "R7");
    look(32'h1122_3344, 1, 0, "R7");

    wr(2, 0, 32'h2000_0000, "R10");
    wr(2, 1, 32'hF000_0000, "R10");
    wr(2, 4, 32'h0000_000C, "R10");
    look(32'h2000_0010, 0, 0, "R7");
    wr(2, 5, 32'h0000_000E, "R10");
    wr(2, 7, 32'hFFFF_FFFF, "R10");
    look(32'h2000_0010, 0, 0, "R10");

    step(1, 32'h2000_0020, 0, 1, 2, 4, 32'h0000_000B, 0, "R10");
    look(32'h2000_0020, 1, 0, "R10");
    step(0, 32'h2000_0020, 0, 0, 0, 0, 32'h0, 0, "R9");
    step(0, 32'h3000_0000, 1, 0, 0, 0, 32'h0, 1, "R9");

    for (int n = 0; n < 600; n++) begin
      bit [31:0] d, ea;
      int f, k;
      k = $urandom_range(0, 3);
      f = $urandom_range(0, 5);
      case (f)
        0: d = (k == 0) ? 32'h1000_0000 : (k == 1) ? 32'h1100_0000 : 32'h2000_0000;
        1: d = k[0] ? 32'hFF00_0000 : 32'hF000_0000;
        4: d = {28'h0, 4'($urandom_range(0, 15))};
        default: d = $urandom;
      endcase
      case ($urandom_range(0, 3))
        0: ea = {8'h10, 24'($urandom)};
        1: ea = {8'h11, 24'($urandom)};
        2: ea = {8'h20, 24'($urandom)};
        default: ea = $urandom;
      endcase
      step($urandom_range(0, 3) != 0, ea, 1'($urandom), $urandom_range(0, 2) == 0,
           $urandom_range(0, 3), f, d, $urandom_range(0, 4) == 0 ? ~m_mode : m_mode, "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule